// File: doc/BRIEF.md
# Tag-Scripted I2C Bus Master

This block is an I2C bus master whose bus transactions are described as a stream of 16-bit command words instead of register writes. Each word has an 8-bit tag in bits 15:8 and an 8-bit payload in bits 7:0. The tag tells the engine what to do next: open a transfer with a START and an address byte, send a data byte, send a data byte and close with a STOP, or clock in a number of bytes from the target. Command words arrive on a valid/ready port. The engine accepts one only when it is idle and enabled.

Bytes read from the target come back as 16-bit result words with the same layout. A tag of 0x85 marks an ordinary byte. 0x86 marks the final byte of a read. 0x87 says the read could not be performed. Both bus lines are open-drain: the block only ever pulls SCL or SDA low, and it reads the real line levels back. The SCL half-period comes from a programmed divider. Four sticky status bits report target NACK, lost arbitration, a bus that was busy at START, and a bad or misplaced tag.

Top module: `i2c_tag_master`

## Requirements
- R1: Tag 0x81 with an idle bus produces a START (SDA falls while SCL is high), then shifts out the payload MSB first as the 7-bit address plus R/W bit (bit 0 = 1 means read), then samples the target's ACK.
- R2: Tag 0x82 sends its payload byte and leaves SCL held low with no STOP. Tag 0x83 sends its payload byte and then issues a STOP (SDA rises while SCL is high).
- R3: Tag 0x84 reads as many bytes as its payload gives. Every byte except the last is ACKed and returned with tag 0x85. The last byte is NACKed, returned with tag 0x86, and followed by a STOP. A count of zero issues a STOP and returns nothing.
- R4: If the target NACKs any transmitted byte, st_nack is set and a STOP is issued. Every following word up to the next 0x81 is consumed without bus activity.
- R5: A 0x84 word consumed while words are being discarded returns exactly one result word, 0x8700.
- R6: A tag outside 0x81..0x84 sets st_bad_tag. If a transfer is open, a STOP follows. A 0x82, 0x83 or 0x84 word with no open transfer also sets st_bad_tag and causes no bus activity.
- R7: One SCL half-period lasts div_val + 3 clock cycles, so a zero divider gives the minimum of 3. A full data-bit SCL period is 2 * (div_val + 3) cycles.
- R8: The high half of a bit starts counting only once the SCL line reads high. A target holding SCL low therefore stretches the low phase but leaves the high phase at div_val + 3 cycles.
- R9: If the engine releases SDA for a 1 bit and reads 0 at the end of the SCL high phase, it sets st_arb_lost, releases both lines and discards words up to the next 0x81.
- R10: A 0x81 word with no open transfer while SCL or SDA reads low sets st_bus_err, generates no START, and starts discarding words.
- R11: Status bits are 0 after reset. Each stays set until a cycle with st_clr high, which clears all four.
- R12: A 0x81 word while a transfer is open produces a repeated START without an intervening STOP.
- R13: While run_en is low, cmd_ready stays low and no command word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows command words to be accepted |
| div_val | input | DIV_W | Half-period divider; half-period = div_val + 3 cycles |
| cmd_valid | input | 1 | Command word valid |
| cmd_data | input | 16 | Command word: tag [15:8], payload [7:0] |
| cmd_ready | output | 1 | Engine takes the command word this cycle |
| rsp_valid | output | 1 | One-cycle pulse with a result word |
| rsp_data | output | 16 | Result word: tag [15:8], byte [7:0] |
| scl_i | input | 1 | SCL line level |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA line level |
| sda_low | output | 1 | Pull SDA low when 1 |
| st_clr | input | 1 | Clears all status bits |
| st_nack | output | 1 | Sticky: target NACKed a transmitted byte |
| st_arb_lost | output | 1 | Sticky: arbitration lost |
| st_bus_err | output | 1 | Sticky: bus busy at START |
| st_bad_tag | output | 1 | Sticky: unknown or misplaced tag |

## Verification
The bench builds the engine with DIV_W = 4 and changes div_val between 0, 2 and 4 at run time. With these short half-periods, the exact SCL period and high time can be compared cycle for cycle against div_val + 3, including the zero-divider minimum. The small width also keeps full read, write, repeated-start, NACK, arbitration and clock-stretch transfers to a few hundred cycles each. A behavioural target on the wired-AND lines answers at a fixed address, logs every byte and every master ACK, and can be told to NACK, stretch SCL, or pin SDA low.

// File: rtl/i2c_tag_pkg.sv
package i2c_tag_pkg;
  // Command and result tags (word bits 15:8)
  localparam logic [7:0] TAG_START  = 8'h81;
  localparam logic [7:0] TAG_DATA   = 8'h82;
  localparam logic [7:0] TAG_STOPD  = 8'h83;
  localparam logic [7:0] TAG_RECV   = 8'h84;
  localparam logic [7:0] TAG_MIDATA = 8'h85;
  localparam logic [7:0] TAG_MISTOP = 8'h86;
  localparam logic [7:0] TAG_MINACK = 8'h87;

  localparam int MIN_DIV = 3;

  // Status flag positions
  localparam int FL_NACK = 0;
  localparam int FL_ARB  = 1;
  localparam int FL_BUS  = 2;
  localparam int FL_TAG  = 3;
  localparam int NFLAG   = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RS0, ST_SA, ST_SB,
    ST_WLO, ST_WHI, ST_ALO, ST_AHI,
    ST_RLO, ST_RHI, ST_MLO, ST_MHI,
    ST_PLO, ST_PHI, ST_PEND
  } bus_st_e;
endpackage

// File: rtl/i2c_tag_prescale.sv
module i2c_tag_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  import i2c_tag_pkg::*;
  localparam int CW = DIV_W + 2;

  logic [CW-1:0] cnt, cnt_d, lim;

  assign lim  = {2'b00, div} + CW'(MIN_DIV - 1);
  assign tick = !clr && !hold && (cnt == lim);

  always_comb begin
    if (clr)       cnt_d = '0;
    else if (hold) cnt_d = cnt;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/i2c_tag_sticky.sv
module i2c_tag_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;

  always_comb q_d = (clr ? '0 : q) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/i2c_tag_master.sv
module i2c_tag_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cmd_valid,
  input  logic [15:0]      cmd_data,
  output logic             cmd_ready,
  output logic             rsp_valid,
  output logic [15:0]      rsp_data,
  input  logic             scl_i,
  output logic             scl_low,
  input  logic             sda_i,
  output logic             sda_low,
  input  logic             st_clr,
  output logic             st_nack,
  output logic             st_arb_lost,
  output logic             st_bus_err,
  output logic             st_bad_tag
);
  import i2c_tag_pkg::*;

  bus_st_e     state, state_d;
  logic [7:0]  sh, sh_d, rcnt, rcnt_d;
  logic [2:0]  bcnt, bcnt_d;
  logic        last_stop, last_stop_d, in_xfer, in_xfer_d, skip, skip_d;
  logic        rsp_v_d;
  logic [15:0] rsp_w_d;
  logic [NFLAG-1:0] fset, flags;
  logic        tick, scl_rel, hold, accept;
  logic [7:0]  tag, pl;

  assign tag       = cmd_data[15:8];
  assign pl        = cmd_data[7:0];
  assign cmd_ready = (state == ST_IDLE) && run_en;
  assign accept    = cmd_ready && cmd_valid;

  always_comb begin
    case (state)
      ST_SA, ST_SB, ST_WHI, ST_AHI, ST_RHI, ST_MHI, ST_PHI: scl_rel = 1'b1;
      default: scl_rel = 1'b0;
    endcase
  end
  assign hold = scl_rel && !scl_i;

  i2c_tag_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE), .hold(hold),
    .div(div_val), .tick(tick)
  );

  i2c_tag_sticky #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(st_clr), .q(flags)
  );

  assign st_nack     = flags[FL_NACK];
  assign st_arb_lost = flags[FL_ARB];
  assign st_bus_err  = flags[FL_BUS];
  assign st_bad_tag  = flags[FL_TAG];

  // Line drive per state
  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (state)
      ST_IDLE: scl_low = in_xfer;
      ST_RS0, ST_ALO, ST_RLO: scl_low = 1'b1;
      ST_SB:   sda_low = 1'b1;
      ST_WLO:  begin scl_low = 1'b1; sda_low = !sh[7]; end
      ST_WHI:  sda_low = !sh[7];
      ST_MLO:  begin scl_low = 1'b1; sda_low = (rcnt != 8'd1); end
      ST_MHI:  sda_low = (rcnt != 8'd1);
      ST_PLO:  begin scl_low = 1'b1; sda_low = 1'b1; end
      ST_PHI:  sda_low = 1'b1;
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d     = state;
    sh_d        = sh;
    rcnt_d      = rcnt;
    bcnt_d      = bcnt;
    last_stop_d = last_stop;
    in_xfer_d   = in_xfer;
    skip_d      = skip;
    rsp_v_d     = 1'b0;
    rsp_w_d     = rsp_data;
    fset        = '0;
    case (state)
      ST_IDLE: if (accept) begin
        if (tag == TAG_START) begin
          skip_d = 1'b0;
          sh_d   = pl;
          if (in_xfer)                state_d = ST_RS0;
          else if (!scl_i || !sda_i) begin
            fset[FL_BUS] = 1'b1;
            skip_d       = 1'b1;
          end else                    state_d = ST_SA;
        end else if (skip) begin
          if (tag == TAG_RECV) begin
            rsp_v_d = 1'b1;
            rsp_w_d = {TAG_MINACK, 8'h00};
          end
        end else if (!in_xfer) begin
          fset[FL_TAG] = 1'b1;
        end else if (tag == TAG_DATA || tag == TAG_STOPD) begin
          sh_d        = pl;
          bcnt_d      = '0;
          last_stop_d = (tag == TAG_STOPD);
          state_d     = ST_WLO;
        end else if (tag == TAG_RECV) begin
          rcnt_d  = pl;
          bcnt_d  = '0;
          state_d = (pl == 8'd0) ? ST_PLO : ST_RLO;
        end else begin
          fset[FL_TAG] = 1'b1;
          state_d      = ST_PLO;
        end
      end
      ST_RS0: if (tick) state_d = ST_SA;
      ST_SA:  if (tick) state_d = ST_SB;
      ST_SB:  if (tick) begin
        state_d     = ST_WLO;
        bcnt_d      = '0;
        in_xfer_d   = 1'b1;
        last_stop_d = 1'b0;
      end
      ST_WLO: if (tick) state_d = ST_WHI;
      ST_WHI: if (tick) begin
        if (sh[7] && !sda_i) begin
          fset[FL_ARB] = 1'b1;
          state_d      = ST_IDLE;
          in_xfer_d    = 1'b0;
          skip_d       = 1'b1;
        end else begin
          sh_d    = {sh[6:0], 1'b0};
          bcnt_d  = bcnt + 3'd1;
          state_d = (bcnt == 3'd7) ? ST_ALO : ST_WLO;
        end
      end
      ST_ALO: if (tick) state_d = ST_AHI;
      ST_AHI: if (tick) begin
        if (sda_i) begin
          fset[FL_NACK] = 1'b1;
          skip_d        = 1'b1;
          state_d       = ST_PLO;
        end else begin
          state_d = last_stop ? ST_PLO : ST_IDLE;
        end
      end
      ST_RLO: if (tick) state_d = ST_RHI;
      ST_RHI: if (tick) begin
        sh_d   = {sh[6:0], sda_i};
        bcnt_d = bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          rsp_v_d = 1'b1;
          rsp_w_d = {(rcnt == 8'd1) ? TAG_MISTOP : TAG_MIDATA, sh[6:0], sda_i};
          state_d = ST_MLO;
        end else begin
          state_d = ST_RLO;
        end
      end
      ST_MLO: if (tick) state_d = ST_MHI;
      ST_MHI: if (tick) begin
        rcnt_d  = rcnt - 8'd1;
        state_d = (rcnt == 8'd1) ? ST_PLO : ST_RLO;
      end
      ST_PLO: if (tick) state_d = ST_PHI;
      ST_PHI: if (tick) state_d = ST_PEND;
      ST_PEND: if (tick) begin
        state_d   = ST_IDLE;
        in_xfer_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sh        <= '0;
      rcnt      <= '0;
      bcnt      <= '0;
      last_stop <= 1'b0;
      in_xfer   <= 1'b0;
      skip      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      state     <= state_d;
      sh        <= sh_d;
      rcnt      <= rcnt_d;
      bcnt      <= bcnt_d;
      last_stop <= last_stop_d;
      in_xfer   <= in_xfer_d;
      skip      <= skip_d;
      rsp_valid <= rsp_v_d;
      rsp_data  <= rsp_w_d;
    end
  end
endmodule

// File: rtl/i2c_tag_master_chk.sv
module i2c_tag_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic [15:0] rsp_data,
  input logic        scl_low,
  input logic        sda_low,
  input logic        st_clr,
  input logic        st_arb_lost,
  input logic [3:0]  flags,
  input logic        in_xfer
);
  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  rsp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[15:8] inside {8'h85, 8'h86, 8'h87}));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_clr |=> ((flags & $past(flags)) == $past(flags)));

  // R9
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_arb_lost) |-> (!scl_low && !sda_low));

  // R13
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !cmd_ready);

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !in_xfer) |-> (!scl_low && !sda_low));
endmodule

bind i2c_tag_master i2c_tag_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .scl_low(scl_low),
  .sda_low(sda_low), .st_clr(st_clr), .st_arb_lost(st_arb_lost),
  .flags({st_bad_tag, st_bus_err, st_arb_lost, st_nack}), .in_xfer(in_xfer)
);

// File: tb/i2c_tag_master_tb.sv
module i2c_tag_master_tb;
  localparam int DIV_W = 4;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, run_en = 1'b1, cmd_valid = 1'b0, st_clr = 1'b0;
  logic [DIV_W-1:0] div_val = 4'd2;
  logic [15:0] cmd_data = '0;
  logic cmd_ready, rsp_valid, scl_low, sda_low;
  logic [15:0] rsp_data;
  logic st_nack, st_arb_lost, st_bus_err, st_bad_tag;
  logic s_drv = 1'b0, jam = 1'b0;
  int str_cnt = 0;
  wire scl_w = ~scl_low & ~(str_cnt != 0);
  wire sda_w = ~sda_low & ~(s_drv | jam);

  i2c_tag_master #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_val(div_val),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .scl_i(scl_w),
    .scl_low(scl_low), .sda_i(sda_w), .sda_low(sda_low), .st_clr(st_clr),
    .st_nack(st_nack), .st_arb_lost(st_arb_lost), .st_bus_err(st_bus_err),
    .st_bad_tag(st_bad_tag)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural target on the wired-AND lines
  int cyc = 0, s_mode = 0, s_bit = 0, s_idx = 0, wn = 0, nstart = 0, nstop = 0;
  int nfall = 0, last_fall = 0, last_rise = 0, period = 0, hi_len = 0;
  int nack_at = -1, rsp_n = 0;
  bit stretch_en = 0;
  logic ps = 1'b1, pd = 1'b1;
  logic [7:0] s_sh = '0;
  logic [7:0] wlog [0:31];
  logic mack [0:15];
  logic [15:0] rsp_q [0:31];

  function automatic logic [7:0] rbyte(input int i);
    return 8'hA0 + i[7:0];
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ps  <= scl_w;
    pd  <= sda_w;
    if (str_cnt > 0) str_cnt <= str_cnt - 1;
    if (rsp_valid) begin rsp_q[rsp_n] <= rsp_data; rsp_n <= rsp_n + 1; end
    if (!ps && scl_w) last_rise <= cyc;
    if (ps && !scl_w) begin
      period <= cyc - last_fall; last_fall <= cyc;
      hi_len <= cyc - last_rise; nfall <= nfall + 1;
    end
    if (ps && scl_w && pd && !sda_w) begin
      s_mode <= 1; s_bit <= 0; s_drv <= 1'b0; nstart <= nstart + 1;
    end else if (ps && scl_w && !pd && sda_w) begin
      s_mode <= 0; s_drv <= 1'b0; nstop <= nstop + 1;
    end else if (!ps && scl_w) begin
      if ((s_mode == 1 || s_mode == 2) && s_bit < 8) begin
        s_sh <= {s_sh[6:0], sda_w}; s_bit <= s_bit + 1;
      end else if (s_mode == 3) begin
        if (s_bit < 8) s_bit <= s_bit + 1;
        else if (s_bit == 8) begin mack[s_idx] <= !sda_w; s_bit <= 9; end
      end
    end else if (ps && !scl_w) begin
      if (s_mode == 1 || s_mode == 2) begin
        if (s_bit == 8) begin
          if (s_mode == 1) begin
            if (s_sh[7:1] == SLV) begin s_drv <= 1'b1; s_bit <= 9; end
            else s_mode <= 0;
          end else if (wn == nack_at) s_mode <= 0;
          else begin
            s_drv <= 1'b1; wlog[wn] <= s_sh; wn <= wn + 1; s_bit <= 9;
            if (stretch_en) str_cnt <= 25;
          end
        end else if (s_bit == 9) begin
          s_bit <= 0;
          if (s_mode == 1 && s_sh[0]) begin
            s_mode <= 3; s_idx <= 0; s_drv <= ~rbyte(0)[7];
          end else begin
            s_mode <= 2; s_drv <= 1'b0;
          end
        end
      end else if (s_mode == 3) begin
        if (s_bit < 8) s_drv <= ~rbyte(s_idx)[7-s_bit];
        else if (s_bit == 8) s_drv <= 1'b0;
        else if (mack[s_idx]) begin
          s_idx <= s_idx + 1; s_bit <= 0; s_drv <= ~rbyte(s_idx + 1)[7];
        end else begin
          s_mode <= 0; s_drv <= 1'b0;
        end
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); st_clr = 1'b1;
    @(negedge clk); st_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 flags after reset", {st_nack, st_arb_lost, st_bus_err, st_bad_tag}, 0);
    chk("R6 lines released after reset", {scl_low, sda_low}, 0);
    chk("R13 ready when enabled", cmd_ready, 1);
  endtask

  task automatic t_write();
    int w0 = wn, p0 = nstop, s0 = nstart;
    div_val = 4'd2;
    send(16'h81A0); send(16'h8211); send(16'h8322); wait_idle();
    chk("R1 one START", nstart - s0, 1);
    chk("R2 bytes written", wn - w0, 2);
    chk("R2 first byte", wlog[w0], 8'h11);
    chk("R2 second byte", wlog[w0+1], 8'h22);
    chk("R2 one STOP", nstop - p0, 1);
    chk("R7 period div2", period, 10);
    chk("R7 high time div2", hi_len, 5);
    chk("R4 no nack", st_nack, 0);
  endtask

  task automatic t_div(input logic [3:0] d);
    int w0 = wn;
    div_val = d;
    send(16'h81A0); send(16'h835A); wait_idle();
    chk("R7 byte at divider", wlog[w0], 8'h5A);
    chk("R7 period", period, 2 * (int'(d) + 3));
    chk("R7 high time", hi_len, int'(d) + 3);
    div_val = 4'd2;
  endtask

  task automatic t_read();
    int r0 = rsp_n, p0 = nstop;
    send(16'h81A1); send(16'h8403); wait_idle();
    chk("R3 result count", rsp_n - r0, 3);
    chk("R3 result 0", rsp_q[r0], 16'h85A0);
    chk("R3 result 1", rsp_q[r0+1], 16'h85A1);
    chk("R3 last result", rsp_q[r0+2], 16'h86A2);
    chk("R3 ack byte 0", mack[0], 1);
    chk("R3 ack byte 1", mack[1], 1);
    chk("R3 nack last", mack[2], 0);
    chk("R3 STOP after read", nstop - p0, 1);
  endtask

  task automatic t_rstart();
    int r0 = rsp_n, s0 = nstart, p0 = nstop, w0 = wn;
    send(16'h81A0); send(16'h8201); send(16'h81A1); send(16'h8401); wait_idle();
    chk("R12 two STARTs", nstart - s0, 2);
    chk("R12 one STOP", nstop - p0, 1);
    chk("R12 byte before restart", wlog[w0], 8'h01);
    chk("R12 read after restart", rsp_q[r0], 16'h86A0);
  endtask

  task automatic t_recv0();
    int r0 = rsp_n, p0 = nstop;
    send(16'h81A1); send(16'h8400); wait_idle();
    chk("R3 zero count no result", rsp_n - r0, 0);
    chk("R3 zero count STOP", nstop - p0, 1);
  endtask

  task automatic t_nack();
    int w0 = wn, s0 = nstart, p0 = nstop, f0;
    clear_flags();
    nack_at = wn;
    send(16'h81A0); send(16'h8233);
    wait_idle();
    f0 = nfall;
    send(16'h8244); send(16'h8355); wait_idle();
    chk("R4 nack flag", st_nack, 1);
    chk("R4 nothing logged", wn - w0, 0);
    chk("R4 one START", nstart - s0, 1);
    chk("R4 STOP issued", nstop - p0, 1);
    chk("R4 discarded words idle", nfall - f0, 0);
    chk("R4 no tag error", st_bad_tag, 0);
    nack_at = -1;
    send(16'h81A0); send(16'h8366); wait_idle();
    chk("R4 START resumes", wlog[w0], 8'h66);
  endtask

  task automatic t_minack();
    int r0 = rsp_n;
    clear_flags();
    send(16'h8161); send(16'h8402); wait_idle();
    chk("R5 nack flag", st_nack, 1);
    chk("R5 one result", rsp_n - r0, 1);
    chk("R5 nack result", rsp_q[r0], 16'h8700);
  endtask

  task automatic t_badtag();
    int p0 = nstop, s0, f0;
    clear_flags();
    send(16'h81A0); send(16'h9955); wait_idle();
    chk("R6 bad tag flag", st_bad_tag, 1);
    chk("R6 STOP after bad tag", nstop - p0, 1);
    chk("R6 lines released", {scl_low, sda_low}, 0);
    clear_flags();
    s0 = nstart; f0 = nfall;
    send(16'h8212); wait_idle();
    chk("R6 data with no transfer flagged", st_bad_tag, 1);
    chk("R6 no bus activity", nfall - f0 + nstart - s0, 0);
  endtask

  task automatic t_stretch();
    int w0 = wn;
    stretch_en = 1;
    send(16'h81A0); send(16'h8377); wait_idle();
    stretch_en = 0;
    chk("R8 byte with stretch", wlog[w0], 8'h77);
    chk("R8 high time kept", hi_len, 5);
    chk("R8 low phase stretched", int'(period >= 30), 1);
  endtask

  task automatic t_arb();
    int s0 = nstart, f0;
    clear_flags();
    send(16'h81A0);
    while (nstart == s0) @(negedge clk);
    jam = 1'b1;
    repeat (40) @(negedge clk);
    chk("R9 arb flag", st_arb_lost, 1);
    chk("R9 lines released", {scl_low, sda_low}, 0);
    jam = 1'b0;
    repeat (5) @(negedge clk);
    f0 = nfall;
    send(16'h8301); wait_idle();
    chk("R9 following word discarded", nfall - f0, 0);
    chk("R9 no tag error on discard", st_bad_tag, 0);
  endtask

  task automatic t_buserr();
    int f0;
    clear_flags();
    jam = 1'b1;
    repeat (3) @(negedge clk);
    f0 = nfall;
    send(16'h81A0); wait_idle();
    chk("R10 bus error flag", st_bus_err, 1);
    chk("R10 no clocking", nfall - f0, 0);
    chk("R10 scl released", scl_low, 0);
    jam = 1'b0;
    repeat (5) @(negedge clk);
    send(16'h8301); wait_idle();
    chk("R10 word discarded", st_bad_tag, 0);
    chk("R10 still no clocking", nfall - f0, 0);
  endtask

  task automatic t_clear();
    chk("R11 flags held before clear", st_bus_err, 1);
    clear_flags();
    @(negedge clk);
    chk("R11 flags cleared", {st_nack, st_arb_lost, st_bus_err, st_bad_tag}, 0);
  endtask

  task automatic t_run();
    int s0 = nstart;
    @(negedge clk); run_en = 1'b0;
    cmd_valid = 1'b1; cmd_data = 16'h81A0;
    @(negedge clk);
    chk("R13 ready low when disabled", cmd_ready, 0);
    repeat (30) @(negedge clk);
    chk("R13 no START when disabled", nstart - s0, 0);
    cmd_valid = 1'b0; run_en = 1'b1;
    @(negedge clk);
    chk("R13 ready back", cmd_ready, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_div(4'd0);
    t_div(4'd4);
    t_read();
    t_rstart();
    t_recv0();
    t_nack();
    t_minack();
    t_badtag();
    t_stretch();
    t_arb();
    t_buserr();
    t_clear();
    t_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule